// File: doc/BRIEF.md
# Load-Use Stall Controller

This block is the hazard-detection logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the instruction in the execute stage with the instruction in decode. If the execute-stage instruction is a load, and its destination register is one of the registers that the decode-stage instruction reads, the loaded value cannot reach the consumer in time, even through forwarding. The block then holds the front of the pipeline for one cycle and turns the instruction entering execute into a bubble.

Dependences between two ALU instructions are left to the forwarding network, so only the load-use case raises a stall. The bubble is made by a select that the surrounding pipeline uses to zero the control word passed on to the execute, memory and writeback stages. The fetch-stage program counter and the fetch/decode register keep their contents while the stall lasts. Register 0 is hard-wired and never creates a dependence.

All outputs are combinational functions of the current inputs. The block holds no state. The one-cycle length of a stall comes from the surrounding pipeline: on the cycle after the stall, the bubble it injected sits in the execute stage.

Top module: `load_use_stall_unit`

## Requirements
- R1: When no stall condition holds, `pc_we` = 1, `ifid_we` = 1 and `ctl_zero` = 0, in the same cycle as the inputs.
- R2: When `ex_is_load` = 1, `ex_dst` is nonzero and `ex_dst` equals `id_src_a`, the outputs are `pc_we` = 0, `ifid_we` = 0 and `ctl_zero` = 1.
- R3: When `ex_is_load` = 1, `ex_dst` is nonzero and `ex_dst` equals `id_src_b`, the outputs are `pc_we` = 0, `ifid_we` = 0 and `ctl_zero` = 1.
- R4: A load whose destination index is 0 never raises a stall, whatever the source fields are.
- R5: When `ex_is_load` = 0, no stall is raised, even if `ex_dst` matches a source field.
- R6: `pc_we` and `ifid_we` are always equal, and `ctl_zero` is always their inverse.
- R7: In a pipeline where the stall zeroes the next execute-stage entry and holds decode, a load followed directly by a dependent instruction gives exactly one stall cycle. Instructions that depend on the load from two or more slots later give none.
- R8: When both source fields match the load destination, the response is the same single stall as for one match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_is_load | input | 1 | Execute-stage instruction reads data memory (is a load) |
| ex_dst | input | REG_AW (5) | Destination register index of the execute-stage instruction |
| id_src_a | input | REG_AW (5) | First source register index of the decode-stage instruction |
| id_src_b | input | REG_AW (5) | Second source register index of the decode-stage instruction |
| pc_we | output | 1 | Program counter write enable (0 holds fetch) |
| ifid_we | output | 1 | Fetch/decode pipeline register write enable (0 holds decode) |
| ctl_zero | output | 1 | Select that zeroes the control word sent to the later stages |

## Verification
Immediate assertions check on every input change that the three outputs agree with each other, that a non-load or a zero destination never stalls, and that a matching load on either source always stalls. The claim of exactly one stall cycle per load-use pair is a property of the block together with the pipeline registers around it. Only the bench's pipeline model can show it: it replays instruction sequences, feeds the bubble back into the execute stage and counts the stall cycles.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    parameter int REG_AW  = 5;
    parameter int NUM_SRC = 2;

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic ctl_zero;
    } stall_ctl_t;

    localparam stall_ctl_t CTL_RUN  = '{pc_we: 1'b1, ifid_we: 1'b1, ctl_zero: 1'b0};
    localparam stall_ctl_t CTL_HOLD = '{pc_we: 1'b0, ifid_we: 1'b0, ctl_zero: 1'b1};

    // Register 0 is hard-wired and never carries a dependence.
    function automatic logic dest_is_live(reg_idx_t idx);
        return idx != '0;
    endfunction

endpackage

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp
    import hzd_pkg::*;
(
    input  logic     ld_valid,
    input  reg_idx_t ld_dst,
    input  reg_idx_t src,
    output logic     hit
);
    always_comb begin
        hit = ld_valid && dest_is_live(ld_dst) && (ld_dst == src);
    end
endmodule

// File: rtl/hzd_stall_gen.sv
module hzd_stall_gen
    import hzd_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] hits,
    output stall_ctl_t   ctl
);
    always_comb begin
        ctl = (|hits) ? CTL_HOLD : CTL_RUN;
    end
endmodule

// File: rtl/load_use_stall_unit.sv
module load_use_stall_unit
    import hzd_pkg::*;
(
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              ctl_zero
);
    reg_idx_t           srcs [NUM_SRC];
    logic [NUM_SRC-1:0] hits;
    stall_ctl_t         ctl;

    always_comb begin
        srcs[0] = id_src_a;
        srcs[1] = id_src_b;
    end

    // One comparator per source field of the decode-stage instruction.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
        hzd_src_cmp u_cmp (
            .ld_valid (ex_is_load),
            .ld_dst   (ex_dst),
            .src      (srcs[g]),
            .hit      (hits[g])
        );
    end

    hzd_stall_gen #(.N(NUM_SRC)) u_gen (
        .hits (hits),
        .ctl  (ctl)
    );

    always_comb begin
        pc_we    = ctl.pc_we;
        ifid_we  = ctl.ifid_we;
        ctl_zero = ctl.ctl_zero;
    end

    always_comb begin
        AST_FRONT_AGREE: assert (pc_we == ifid_we);                                      // R6
        AST_BUBBLE_EXCLUSIVE: assert (ctl_zero != pc_we);                                // R6
        AST_NO_LOAD_NO_STALL: assert (ex_is_load || !ctl_zero);                          // R5
        AST_ZERO_DEST_QUIET: assert ((ex_dst != '0) || !ctl_zero);                       // R4
        AST_SRC_A_STALLS: assert (!(ex_is_load && ex_dst != '0 && ex_dst == id_src_a) || ctl_zero); // R2
        AST_SRC_B_STALLS: assert (!(ex_is_load && ex_dst != '0 && ex_dst == id_src_b) || ctl_zero); // R3
        AST_RUN_WITHOUT_MATCH: assert ((ex_dst == id_src_a) || (ex_dst == id_src_b) || pc_we);  // R1
    end
endmodule

// File: tb/load_use_stall_unit_tb.sv
`timescale 1ns/1ps
module load_use_stall_unit_tb_top;

    typedef struct {
        bit    stall;
        string tag;
    } exp_t;

    typedef struct {
        bit       ld;
        bit [4:0] dst;
        bit [4:0] sa;
        bit [4:0] sb;
    } instr_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ex_is_load;
    logic [4:0] ex_dst, id_src_a, id_src_b;
    logic       pc_we, ifid_we, ctl_zero;

    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;
    exp_t sb_q[$];
    int   stall_seen = 0;

    always #2 clk = ~clk;

    load_use_stall_unit dut_i (
        .ex_is_load (ex_is_load),
        .ex_dst     (ex_dst),
        .id_src_a   (id_src_a),
        .id_src_b   (id_src_b),
        .pc_we      (pc_we),
        .ifid_we    (ifid_we),
        .ctl_zero   (ctl_zero)
    );

    // Monitor: pops expectations at the falling edge and compares.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (ctl_zero) stall_seen++;
            if ({pc_we, ifid_we, ctl_zero} != {~e.stall, ~e.stall, e.stall}) begin
                failures++;
                $display("FAIL %s: got pc_we=%0b ifid_we=%0b ctl_zero=%0b expected %0b %0b %0b",
                         e.tag, pc_we, ifid_we, ctl_zero, ~e.stall, ~e.stall, e.stall);
            end
        end
    end

    // Driver for isolated input patterns.
    task automatic drive(input bit ld, input bit [4:0] d, input bit [4:0] a,
                         input bit [4:0] b, input bit stall, input string tag);
        exp_t e;
        @(posedge clk);
        #0.5;
        ex_is_load = ld; ex_dst = d; id_src_a = a; id_src_b = b;
        e.stall = stall; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Reference stall rule, taken from the requirements.
    function automatic bit ref_stall(instr_t ex, instr_t id);
        return ex.ld && ex.dst != 0 && (ex.dst == id.sa || ex.dst == id.sb);
    endfunction

    // Pipeline model: an instruction sequence flows through decode and execute.
    task automatic run_prog(input instr_t prog[$], input int exp_stalls, input string tag);
        instr_t ifid, idex, nop;
        int     pc;
        bit     st;
        int     base;
        nop = '{0, 0, 0, 0};
        ifid = nop; idex = nop; pc = 0; st = 0;
        @(posedge clk);
        #0.2;
        base = stall_seen;
        for (int cyc = 0; cyc < prog.size() + 4; cyc++) begin
            exp_t e;
            @(posedge clk);
            #0.5;
            if (st) begin
                idex = nop;
            end else begin
                idex = ifid;
                ifid = (pc < prog.size()) ? prog[pc] : nop;
                pc++;
            end
            ex_is_load = idex.ld; ex_dst = idex.dst;
            id_src_a = ifid.sa; id_src_b = ifid.sb;
            st = ref_stall(idex, ifid);
            e.stall = st; e.tag = tag;
            sb_q.push_back(e);
        end
        @(posedge clk);
        @(negedge clk);
        #0.2;
        checks++;
        if (stall_seen - base != exp_stalls) begin
            failures++;
            $display("FAIL %s: stall cycles got %0d expected %0d", tag, stall_seen - base, exp_stalls);
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        instr_t p1[$], p2[$], p3[$];
        ex_is_load = 0; ex_dst = 0; id_src_a = 0; id_src_b = 0;
        repeat (2) @(posedge clk);
        rst = 1'b0;

        drive(0, 0, 0, 0, 0, "R1 idle after reset");
        drive(0, 7, 1, 3, 0, "R1 alu no match");
        drive(1, 9, 4, 5, 0, "R1 load no match");
        drive(1, 2, 2, 5, 1, "R2 load dst==src_a");
        drive(1, 31, 31, 0, 1, "R2 top index src_a");
        drive(1, 6, 4, 6, 1, "R3 load dst==src_b");
        drive(1, 1, 0, 1, 1, "R3 index 1 src_b");
        drive(1, 0, 0, 0, 0, "R4 load to r0, both src r0");
        drive(1, 0, 0, 5, 0, "R4 load to r0, src_a r0");
        drive(0, 4, 4, 4, 0, "R5 alu result matches both");
        drive(0, 12, 3, 12, 0, "R5 alu result matches src_b");
        drive(1, 14, 14, 14, 1, "R8 both sources match");
        drive(1, 3, 3, 8, 1, "R6 stall then release");
        drive(0, 3, 3, 8, 0, "R6 release");

        // load x2; and uses x2; or uses x2; add uses x2
        p1 = '{'{1, 2, 1, 0}, '{0, 12, 2, 5}, '{0, 13, 6, 2}, '{0, 14, 2, 2}};
        run_prog(p1, 1, "R7 single load-use pair");
        // load x4; independent; consumer of x4 two slots later
        p2 = '{'{1, 4, 1, 0}, '{0, 9, 6, 7}, '{0, 10, 4, 4}};
        run_prog(p2, 0, "R7 consumer two slots later");
        // two back-to-back load-use pairs
        p3 = '{'{1, 4, 3, 0}, '{1, 6, 4, 3}, '{0, 7, 6, 2}};
        run_prog(p3, 2, "R7 chained load-use pairs");

        repeat (3) @(posedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule